// File: doc/BRIEF.md
# Windowed Decoder Error Rate Monitor

This block collects error statistics from three taps of a concatenated receive decoder chain. It counts channel bit errors reported by the inner decoder, bits repaired by the outer block decoder, and packets the outer decoder could not repair. All three are summed over a measurement window whose length is programmed in packets. When a window closes, the three sums are copied together into readable result registers, and the running sums restart from zero.

A host reads the results one byte at a time through a small read port. A multi-byte result is read coherently: reading its least significant byte captures the whole value, so a window that closes during the read cannot mix two windows. An active-low, maskable interrupt reports each closed window. Reading the interrupt status byte releases it.

A status pin carries a square wave whose frequency follows the inner-decoder error count of the last window. An installer can hear it while aligning a dish. A zero count keeps the pin quiet.

Top module: `erm_monitor`

## Requirements
- R1: The inner error result is 24 bits and sums `inner_err_inc` over the window. The outer correction result is 24 bits and sums `outer_fix_inc`. The packet-loss result is 16 bits and counts the cycles in which `pkt_end` and `pkt_uncorr` are both high. `pkt_uncorr` without `pkt_end` is ignored.
- R2: A window closes on the clock edge that accepts the `win_len`-th `pkt_end` pulse; a `win_len` of 0 behaves as 1. On that edge, all three results are loaded with their sums, including that cycle's increments, and the running sums are cleared.
- R3: Each running sum saturates at its all-ones value instead of wrapping.
- R4: Read map, with bytes least significant first: addresses 0 to 2 hold the inner result, 3 to 5 the outer result, 6 to 7 the packet-loss result, and 8 the interrupt status in bit 0. Other addresses read 0. `rd_data` is updated on the edge that samples `rd_en` and is then held.
- R5: A closed window sets a pending flag. `irq_n` is low while the flag is set and `irq_en` is high. A read of address 8 returns the flag and clears it; a window closing in the same cycle keeps it set.
- R6: With `irq_en` low, `irq_n` stays high, but the pending flag is still set and can be read at address 8.
- R7: Reading the low byte of a result captures the whole value. Its upper bytes then return the captured value until its most significant byte has been read; after that they return live values again.
- R8: A `PHASE_W`-bit phase accumulator adds, every cycle, the step min(inner result << `tone_shift`, 2^(PHASE_W-1)). `tone_out` is its registered top bit, so the tone produces step/2^PHASE_W rising edges per cycle.
- R9: While the inner result is zero, `tone_out` is 0 from the next cycle onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inner_err_inc | input | INC_W | Bit errors found by the inner decoder this cycle |
| outer_fix_inc | input | INC_W | Bits corrected by the outer decoder this cycle |
| pkt_end | input | 1 | One-cycle pulse at the end of each packet |
| pkt_uncorr | input | 1 | The packet ending this cycle was uncorrectable |
| win_len | input | WIN_W | Window length in packets |
| tone_shift | input | SHIFT_W | Left shift applied to the count to form the tone step |
| irq_en | input | 1 | Interrupt mask, 1 = enabled |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low window-done interrupt |
| tone_out | output | 1 | Error-rate tone |

## Verification
The window results change on the edge that takes the closing `pkt_end`, and `irq_n` falls after that same edge. `rd_data` belongs to the edge that samples `rd_en`. `tone_out` follows a new inner result one cycle later. The bench drives at the falling edge and samples each result at the next falling edge after the edge that produces it, keeping its own model of the saturating sums and packet counts. Tone frequency is checked by counting rising edges over a fixed span, with a tolerance of one edge for the starting phase.

// File: rtl/erm_pkg.sv
package erm_pkg;

  // bytes needed to hold a counter of width w
  function automatic int unsigned erm_nbytes(int unsigned w);
    return (w + 7) / 8;
  endfunction

  // add with clamp at the all-ones value of a w-bit counter (w <= 32)
  function automatic logic [31:0] erm_sat_add(logic [31:0] a, logic [31:0] b,
                                              int unsigned w);
    logic [32:0] sum;
    logic [32:0] top;
    sum = {1'b0, a} + {1'b0, b};
    top = (33'd1 << w) - 33'd1;
    return (sum > top) ? top[31:0] : sum[31:0];
  endfunction

  // tone step: count shifted left, capped at half the phase range
  function automatic logic [31:0] erm_tone_step(logic [31:0] cnt, int unsigned sh,
                                                int unsigned pw);
    logic [63:0] wide;
    logic [63:0] cap;
    wide = {32'd0, cnt} << sh;
    cap  = 64'd1 << (pw - 1);
    return (wide > cap) ? cap[31:0] : wide[31:0];
  endfunction

endpackage

// File: rtl/erm_win_ctrl.sv
module erm_win_ctrl #(
  parameter int WIN_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_end,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_done
);
  logic [WIN_W-1:0] pcount;
  logic [WIN_W:0]   limit;
  logic [WIN_W:0]   next_cnt;

  always_comb begin
    limit    = (win_len == '0) ? (WIN_W+1)'(1) : {1'b0, win_len};
    next_cnt = {1'b0, pcount} + (WIN_W+1)'(1);
    win_done = pkt_end && (next_cnt >= limit);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       pcount <= '0;
    else if (win_done) pcount <= '0;
    else if (pkt_end)  pcount <= next_cnt[WIN_W-1:0];
  end
endmodule

// File: rtl/erm_win_acc.sv
module erm_win_acc
  import erm_pkg::*;
#(
  parameter int W  = 24,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] inc,
  input  logic          win_done,
  output logic [W-1:0]  acc,
  output logic [W-1:0]  lat
);
  logic [31:0] sum32;
  logic [W-1:0] total;

  always_comb begin
    sum32 = erm_sat_add(32'(acc), 32'(inc), W);
    total = sum32[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      lat <= '0;
    end else if (win_done) begin
      lat <= total;
      acc <= '0;
    end else begin
      acc <= total;
    end
  end
endmodule

// File: rtl/erm_tone_gen.sv
module erm_tone_gen
  import erm_pkg::*;
#(
  parameter int CNT_W   = 24,
  parameter int PHASE_W = 16,
  parameter int SHIFT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tone_out
);
  logic [31:0]        step32;
  logic [PHASE_W-1:0] step;
  logic [PHASE_W-1:0] phase;
  logic [PHASE_W-1:0] phase_nx;

  always_comb begin
    step32   = erm_tone_step(32'(cnt), int'(shift), PHASE_W);
    step     = step32[PHASE_W-1:0];
    phase_nx = phase + step;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= '0;
      tone_out <= 1'b0;
    end else begin
      phase    <= phase_nx;
      tone_out <= (step == '0) ? 1'b0 : phase_nx[PHASE_W-1];
    end
  end
endmodule

// File: rtl/erm_host_port.sv
module erm_host_port
  import erm_pkg::*;
#(
  parameter int W0     = 24,
  parameter int W1     = 24,
  parameter int W2     = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0][31:0]  lat_pad,
  input  logic              win_done,
  input  logic              irq_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq_n,
  output logic              pending,
  output logic [2:0]        frozen,
  output logic [2:0][31:0]  hold
);
  localparam int NB0   = int'(erm_nbytes(W0));
  localparam int NB1   = int'(erm_nbytes(W1));
  localparam int NB2   = int'(erm_nbytes(W2));
  localparam int A_IRQ = NB0 + NB1 + NB2;
  localparam int BASE [3] = '{0, NB0, NB0 + NB1};
  localparam int NBS  [3] = '{NB0, NB1, NB2};

  logic [2:0][7:0] byte_g;
  logic [2:0]      hit_g;
  logic            irq_hit;

  for (genvar g = 0; g < 3; g++) begin : g_cnt
    int          idx;
    logic        hit_low;
    logic        hit_top;
    logic        in_rng;
    logic [31:0] src;
    logic [7:0]  b_loc;

    always_comb begin
      idx     = int'(rd_addr) - BASE[g];
      in_rng  = rd_en && (idx >= 0) && (idx < NBS[g]);
      hit_low = in_rng && (idx == 0);
      hit_top = in_rng && (idx == NBS[g] - 1);
      src     = (frozen[g] && idx != 0) ? hold[g] : lat_pad[g];
      b_loc   = in_rng ? 8'(src >> (8 * idx)) : 8'd0;
    end

    assign byte_g[g] = b_loc;
    assign hit_g[g]  = in_rng;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hold[g]   <= '0;
        frozen[g] <= 1'b0;
      end else if (hit_low) begin
        hold[g]   <= lat_pad[g];
        frozen[g] <= 1'b1;
      end else if (hit_top) begin
        frozen[g] <= 1'b0;
      end
    end
  end

  assign irq_hit = rd_en && (int'(rd_addr) == A_IRQ);
  assign irq_n   = !(pending && irq_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0;
      pending <= 1'b0;
    end else begin
      if (rd_en) begin
        if (|hit_g)      rd_data <= byte_g[0] | byte_g[1] | byte_g[2];
        else if (irq_hit) rd_data <= {7'd0, pending};
        else             rd_data <= 8'd0;
      end
      if (win_done)     pending <= 1'b1;
      else if (irq_hit) pending <= 1'b0;
    end
  end
endmodule

// File: rtl/erm_monitor.sv
module erm_monitor #(
  parameter int INNER_W = 24,
  parameter int OUTER_W = 24,
  parameter int PKT_W   = 16,
  parameter int INC_W   = 4,
  parameter int WIN_W   = 20,
  parameter int PHASE_W = 16,
  parameter int SHIFT_W = 4,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INC_W-1:0]   inner_err_inc,
  input  logic [INC_W-1:0]   outer_fix_inc,
  input  logic               pkt_end,
  input  logic               pkt_uncorr,
  input  logic [WIN_W-1:0]   win_len,
  input  logic [SHIFT_W-1:0] tone_shift,
  input  logic               irq_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [7:0]         rd_data,
  output logic               irq_n,
  output logic               tone_out
);
  logic               win_done;
  logic               lost_pkt;
  logic [INNER_W-1:0] acc_inner, lat_inner;
  logic [OUTER_W-1:0] acc_outer, lat_outer;
  logic [PKT_W-1:0]   acc_pkt, lat_pkt;
  logic [2:0][31:0]   lat_pad;
  logic [2:0][31:0]   hold;
  logic [2:0]         frozen;
  logic               pending;

  assign lost_pkt = pkt_end && pkt_uncorr;
  assign lat_pad  = {32'(lat_pkt), 32'(lat_outer), 32'(lat_inner)};

  erm_win_ctrl #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .pkt_end(pkt_end), .win_len(win_len),
    .win_done(win_done)
  );

  erm_win_acc #(.W(INNER_W), .IW(INC_W)) u_acc_inner (
    .clk(clk), .rst_n(rst_n), .inc(inner_err_inc), .win_done(win_done),
    .acc(acc_inner), .lat(lat_inner)
  );

  erm_win_acc #(.W(OUTER_W), .IW(INC_W)) u_acc_outer (
    .clk(clk), .rst_n(rst_n), .inc(outer_fix_inc), .win_done(win_done),
    .acc(acc_outer), .lat(lat_outer)
  );

  erm_win_acc #(.W(PKT_W), .IW(1)) u_acc_pkt (
    .clk(clk), .rst_n(rst_n), .inc(lost_pkt), .win_done(win_done),
    .acc(acc_pkt), .lat(lat_pkt)
  );

  erm_tone_gen #(.CNT_W(INNER_W), .PHASE_W(PHASE_W), .SHIFT_W(SHIFT_W)) u_tone (
    .clk(clk), .rst_n(rst_n), .cnt(lat_inner), .shift(tone_shift),
    .tone_out(tone_out)
  );

  erm_host_port #(.W0(INNER_W), .W1(OUTER_W), .W2(PKT_W), .ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst_n(rst_n), .lat_pad(lat_pad), .win_done(win_done),
    .irq_en(irq_en), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_n(irq_n), .pending(pending), .frozen(frozen), .hold(hold)
  );
endmodule

// File: rtl/erm_monitor_chk.sv
module erm_monitor_chk #(
  parameter int INNER_W = 24,
  parameter int PKT_W   = 16,
  parameter int ADDR_W  = 4,
  parameter int A_IRQ   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               win_done,
  input logic [INNER_W-1:0] acc_inner,
  input logic [INNER_W-1:0] lat_inner,
  input logic [PKT_W-1:0]   acc_pkt,
  input logic [PKT_W-1:0]   lat_pkt,
  input logic               tone_out,
  input logic               rd_en,
  input logic [ADDR_W-1:0]  rd_addr,
  input logic               pending,
  input logic               irq_n,
  input logic [2:0]         frozen,
  input logic [2:0][31:0]   hold
);
  // R2: results move only on a closing edge
  p_lat_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !win_done |=> ($stable(lat_inner) && $stable(lat_pkt)));

  // R2: running sums restart after a closing edge
  p_acc_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> (acc_inner == '0 && acc_pkt == '0));

  // R3: a full sum stays full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pkt == '1 && !win_done) |=> (acc_pkt == '1));

  // R5: window close raises the pending flag
  p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> pending);

  // R5: status read releases the interrupt
  p_irq_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && int'(rd_addr) == A_IRQ && !win_done) |=> irq_n);

  // R7: captured value stays put until recaptured
  p_freeze_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen[0] && !(rd_en && rd_addr == '0)) |=> $stable(hold[0]));

  // R9: zero count gives a quiet pin
  p_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_inner == '0) |=> !tone_out);
endmodule

bind erm_monitor erm_monitor_chk #(
  .INNER_W(INNER_W), .PKT_W(PKT_W), .ADDR_W(ADDR_W),
  .A_IRQ((INNER_W + 7) / 8 + (OUTER_W + 7) / 8 + (PKT_W + 7) / 8)
) u_chk (
  .clk(clk), .rst_n(rst_n), .win_done(win_done), .acc_inner(acc_inner),
  .lat_inner(lat_inner), .acc_pkt(acc_pkt), .lat_pkt(lat_pkt),
  .tone_out(tone_out), .rd_en(rd_en), .rd_addr(rd_addr), .pending(pending),
  .irq_n(irq_n), .frozen(frozen), .hold(hold)
);

// File: tb/erm_monitor_tb.sv
module erm_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PHASE_W    = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] inner_err_inc = '0;
  logic [3:0] outer_fix_inc = '0;
  logic       pkt_end = 1'b0;
  logic       pkt_uncorr = 1'b0;
  logic [19:0] win_len = '0;
  logic [3:0] tone_shift = '0;
  logic       irq_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       irq_n;
  logic       tone_out;

  int n_checks = 0;
  int n_fail = 0;
  longint e_in, e_out, e_pk;

  always #(CLK_PERIOD/2) clk = ~clk;

  erm_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .inner_err_inc(inner_err_inc),
    .outer_fix_inc(outer_fix_inc), .pkt_end(pkt_end), .pkt_uncorr(pkt_uncorr),
    .win_len(win_len), .tone_shift(tone_shift), .irq_en(irq_en),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n),
    .tone_out(tone_out)
  );

  function automatic longint clamp(longint v, int w);
    longint top = (longint'(1) << w) - 1;
    return (v > top) ? top : v;
  endfunction

  function automatic longint step_of(longint cnt, int sh);
    longint cap = longint'(1) << (PHASE_W - 1);
    longint s = cnt * (longint'(1) << sh);
    return (s > cap) ? cap : s;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(int a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 4'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rd_cnt(int base, int nb, output longint v);
    logic [7:0] b;
    v = 0;
    for (int i = 0; i < nb; i++) begin
      rd(base + i, b);
      v = v | (longint'(b) << (8 * i));
    end
  endtask

  // mode 0: random traffic; mode 1: packet every cycle, all lost, fixed rates
  task automatic run_window(int len, int mode, int finc);
    longint m_in = 0, m_out = 0, m_pk = 0;
    int pc = 0;
    int eff = (len == 0) ? 1 : len;
    win_len = 20'(len);
    forever begin
      @(negedge clk);
      if (mode == 0) begin
        inner_err_inc = ($urandom % 2) ? 4'($urandom) : 4'd0;
        outer_fix_inc = 4'($urandom % 6);
        pkt_end       = ($urandom % 3) == 0;
        pkt_uncorr    = $urandom % 2;
      end else begin
        inner_err_inc = 4'(finc);
        outer_fix_inc = 4'(finc / 2);
        pkt_end       = 1'b1;
        pkt_uncorr    = 1'b1;
      end
      m_in  = clamp(m_in + inner_err_inc, 24);
      m_out = clamp(m_out + outer_fix_inc, 24);
      if (pkt_end && pkt_uncorr) m_pk = clamp(m_pk + 1, 16);
      if (pkt_end) begin
        pc++;
        if (pc >= eff) break;
      end
    end
    @(negedge clk);
    inner_err_inc = '0; outer_fix_inc = '0; pkt_end = 1'b0; pkt_uncorr = 1'b0;
    e_in = m_in; e_out = m_out; e_pk = m_pk;
  endtask

  task automatic check_results(string tag);
    longint v;
    rd_cnt(0, 3, v); check(v == e_in,  {tag, " R1 inner"}, v, e_in);
    rd_cnt(3, 3, v); check(v == e_out, {tag, " R1 outer"}, v, e_out);
    rd_cnt(6, 2, v); check(v == e_pk,  {tag, " R1 lost"},  v, e_pk);
  endtask

  task automatic count_edges(int cycles, output int edges, output int highs);
    logic prev;
    edges = 0; highs = 0;
    @(negedge clk);
    prev = tone_out;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (tone_out && !prev) edges++;
      if (tone_out) highs++;
      prev = tone_out;
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    longint v;
    int edges, highs;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check(irq_n == 1'b1, "R5 reset irq_n", irq_n, 1);
    check(tone_out == 1'b0, "R9 reset tone", tone_out, 0);
    rd(0, b); check(b == 0, "R4 reset byte0", b, 0);
    rd(11, b); check(b == 0, "R4 unmapped read", b, 0);

    // random windows with interrupt enabled
    irq_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      run_window(5 + int'($urandom % 36), 0, 0);
      check(irq_n == 1'b0, "R5 irq asserted after window", irq_n, 0);
      check_results("rand R2");
      rd(8, b); check(b == 1, "R5 status read", b, 1);
      @(negedge clk);
      check(irq_n == 1'b1, "R5 irq released", irq_n, 1);
      rd(8, b); check(b == 0, "R5 status cleared", b, 0);
    end

    // window length zero acts as one packet
    run_window(0, 1, 3);
    check(e_in == 3, "R2 model len0", e_in, 3);
    check_results("len0 R2");
    rd(8, b);

    // masked interrupt
    irq_en = 1'b0;
    run_window(7, 0, 0);
    check(irq_n == 1'b1, "R6 masked irq_n", irq_n, 1);
    check_results("mask R6");
    rd(8, b); check(b == 1, "R6 pending readable", b, 1);

    // coherent multi-byte read
    run_window(5, 1, 1);
    rd(0, b); check(b == 5, "R7 low byte", b, 5);
    run_window(40, 1, 15);
    rd(1, b); check(b == 0, "R7 frozen mid byte", b, 0);
    rd(2, b); check(b == 0, "R7 frozen top byte", b, 0);
    rd(1, b); check(b == 8'((600 >> 8)), "R7 released mid byte", b, 2);
    rd_cnt(0, 3, v); check(v == 600, "R7 fresh value", v, 600);

    // tone frequency
    run_window(8, 1, 1);
    tone_shift = 4'd4;
    repeat (3) @(negedge clk);
    count_edges(4096, edges, highs);
    v = (4096 * step_of(8, 4)) >> PHASE_W;
    check(edges >= v - 1 && edges <= v + 1, "R8 tone rate shift4", edges, v);
    tone_shift = 4'd15;
    repeat (3) @(negedge clk);
    count_edges(4096, edges, highs);
    v = (4096 * step_of(8, 15)) >> PHASE_W;
    check(edges >= v - 1 && edges <= v + 1, "R8 tone rate capped", edges, v);

    // zero count silences the tone
    run_window(6, 1, 0);
    repeat (2) @(negedge clk);
    count_edges(1000, edges, highs);
    check(highs == 0, "R9 silent tone", highs, 0);

    // saturation of the lost-packet sum
    run_window(70000, 1, 15);
    check_results("sat R3");
    check(e_pk == 65535, "R3 model saturated", e_pk, 65535);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule